// File: doc/BRIEF.md
# 8b/10b Word Decoder with Idle Removal

This block sits behind a word aligner in a serial receive path. Every clock it accepts one aligned 10-bit line word and turns it into a byte. With each byte it gives a flag that marks a control character, a flag for a code that no transmitter could have produced, and a flag for a running-disparity violation. The results leave through a single register stage and carry a valid strobe. That strobe feeds the write side of a clock-crossing FIFO further downstream.

The receive side runs on a clock slightly faster than the core clock that drains the FIFO. To let the two rates match, the block can drop every received comma/idle character (K28.5). This mode is switched by an asynchronous input, which is brought into the decoder clock domain before it is used. A dropped idle produces a cycle with the valid strobe low. No other word is ever dropped.

Top module: `dec8b10b_idle`

## Requirements
- R1: Line bit 0 is the first received bit (a), and bits 1 to 9 are b, c, d, e, i, f, g, h, j. A data code group decodes to byte HGFEDCBA. EDCBA comes from the 6-bit sub-block abcdei and HGF from the 4-bit sub-block fghj. The control flag is low for data.
- R2: Twelve code groups are valid control characters: K28.0 to K28.7 (bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC) and K23.7, K27.7, K29.7 and K30.7 (0xF7, 0xFB, 0xFD, 0xFE). Each decodes to its byte with the control flag high, in either disparity form.
- R3: A word is valid if an encoder could send it from either starting disparity. Any other word raises the invalid-code flag. While that flag is high, the byte and the control flag carry no meaning.
- R4: The disparity-error flag rises when the running disparity is positive and the word has more than five ones. It also rises when the running disparity is negative and the word has fewer than five ones.
- R5: After reset the running disparity is negative. Every received word updates it, including invalid and dropped words: more than five ones makes it positive, fewer than five makes it negative, and exactly five leaves it unchanged.
- R6: While removal is in effect, a K28.5 word in either form (0x17C or 0x283 on the line) produces a cycle with the valid strobe low. Every other word is still delivered.
- R7: The removal input passes through three flops. A level sampled at clock edge k governs the word captured at edge k+3.
- R8: A word captured at one edge appears on every output after that same edge, so all output fields line up in one cycle.
- R9: While reset (active low, synchronous) is held, the valid strobe and both error flags are low.
- R10: With removal not in effect, K28.5 is delivered as a valid control byte 0xBC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock (fast receive clock) |
| rstN | input | 1 | Synchronous reset, active low |
| idleDelAsync | input | 1 | Asynchronous enable for dropping K28.5 |
| inWord | input | 10 | Aligned line word, bit 0 received first |
| outValid | output | 1 | Write strobe for the downstream FIFO |
| outByte | output | 8 | Decoded byte HGFEDCBA |
| outCtrl | output | 1 | High for a control character |
| outCodeErr | output | 1 | Word is not a legal code group |
| outDispErr | output | 1 | Running-disparity violation |

## Verification
The assertions check these relations on every cycle:
- the running-disparity state follows the ones count of each word (R5);
- a word that extends a positive disparity is flagged (R4);
- a K28.5 word arriving while removal is in effect never produces a strobe (R6);
- the removal enable changes exactly three edges after its input (R7);
- every decoded control byte has one of the two legal control shapes (R2).

The exact byte values, the boundary between legal and illegal code groups (R1, R3) and the first idle actually dropped after the input toggles can only be shown by the bench. To do this, the bench builds its own encoder, sweeps all 1024 line words with removal off and then on, and replays encoded streams. It also forces repeated same-polarity words.

// File: rtl/dec8b10b_pkg.sv
package dec8b10b_pkg;

  localparam int WORD_W  = 10;
  localparam int BYTE_W  = 8;
  localparam int SUB6_W  = 6;
  localparam int SUB4_W  = 4;
  localparam int LOW_W   = 5;
  localparam int HIGH_W  = 3;
  localparam int NUM_LOW = 1 << LOW_W;
  localparam int NEUTRAL_ONES = WORD_W / 2;

  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hBC;
  localparam logic [SUB6_W-1:0] K28_SUB6  = 6'b001111;
  localparam logic [SUB4_W-1:0] PRI7_NEG  = 4'b1110;
  localparam logic [SUB4_W-1:0] ALT7_NEG  = 4'b0111;

  // Strobes from control to datapath
  typedef struct packed {
    logic keep;
    logic dispErr;
  } strobe_t;

  // Result of decoding the word under one assumed starting disparity
  typedef struct packed {
    logic              ok;
    logic              ctrl;
    logic [BYTE_W-1:0] value;
  } pathRes_t;

  // 6-bit sub-block (abcdei, a at MSB) used from negative disparity
  function automatic logic [SUB6_W-1:0] sub6Neg(input logic [LOW_W-1:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // A sub-block is inverted for positive disparity if unbalanced or the
  // balanced-but-polarised pattern
  function automatic logic flips6(input logic [SUB6_W-1:0] c);
    return ($countones(c) != 3) || (c == 6'b111000);
  endfunction

  function automatic logic flips4(input logic [SUB4_W-1:0] c);
    return ($countones(c) != 2) || (c == 4'b1100);
  endfunction

  // 4-bit sub-block (fghj, f at MSB) for data, values 0..6, negative column
  function automatic logic [SUB4_W-1:0] sub4Neg(input logic [HIGH_W-1:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      default: return 4'b0110;
    endcase
  endfunction

  // 4-bit sub-block following K28, negative column
  function automatic logic [SUB4_W-1:0] k28Sub4Neg(input logic [HIGH_W-1:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b0110;
      3'd2: return 4'b1010;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b0101;
      3'd6: return 4'b1001;  default: return 4'b0111;
    endcase
  endfunction

  // Data value 7 takes the alternate form for these lows at this disparity
  function automatic logic needAlt(input logic [LOW_W-1:0] x, input logic rdPos);
    if (rdPos) return (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
    return (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
  endfunction

  // Lows that form a control character with the alternate 7 sub-block
  function automatic logic isKx7(input logic [LOW_W-1:0] x);
    return (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
  endfunction

endpackage

// File: rtl/dec8b10b_ctrl.sv
module dec8b10b_ctrl
  import dec8b10b_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    idleDelAsync,
  input  logic    wordIsIdle,
  input  logic    wordPos,
  input  logic    wordNeg,
  output strobe_t strobes,
  output logic    delEn,
  output logic    rdPos
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= idleDelAsync;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[TOP-1:0], idleDelAsync};
      end
    end
  endgenerate

  assign delEn = syncQ[TOP];

  // Running disparity: negative after reset, follows every word
  always_ff @(posedge clk) begin
    if (!rstN)        rdPos <= 1'b0;
    else if (wordPos) rdPos <= 1'b1;
    else if (wordNeg) rdPos <= 1'b0;
  end

  always_comb begin
    strobes.keep    = !(delEn && wordIsIdle);
    strobes.dispErr = rdPos ? wordPos : wordNeg;
  end

endmodule

// File: rtl/dec8b10b_datapath.sv
module dec8b10b_datapath
  import dec8b10b_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  strobe_t           strobes,
  output logic              wordIsIdle,
  output logic              wordPos,
  output logic              wordNeg,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              outCtrl,
  output logic              outCodeErr,
  output logic              outDispErr
);

  logic [SUB6_W-1:0]  s6;
  logic [SUB4_W-1:0]  s4;
  logic [NUM_LOW-1:0] hit6N, hit6P;
  logic [LOW_W-1:0]   low6;
  logic [1:0]         isK28;
  logic [1:0]         hit6;
  pathRes_t           pathR [2];
  logic               codeOk;
  logic               ctrlDec;
  logic [BYTE_W-1:0]  byteDec;

  // Unpack sub-blocks: line bit 0 is 'a' and lands in the MSB of s6
  always_comb begin
    for (int i = 0; i < SUB6_W; i++) s6[SUB6_W-1-i] = inWord[i];
    for (int i = 0; i < SUB4_W; i++) s4[SUB4_W-1-i] = inWord[SUB6_W+i];
  end

  // One comparator pair per 5-bit value, columns derived from the table
  for (genvar gx = 0; gx < NUM_LOW; gx++) begin : g_sub6
    localparam logic [SUB6_W-1:0] CODE_N = sub6Neg(gx[LOW_W-1:0]);
    localparam logic [SUB6_W-1:0] CODE_P = flips6(CODE_N) ? ~CODE_N : CODE_N;
    assign hit6N[gx] = (s6 == CODE_N);
    assign hit6P[gx] = (s6 == CODE_P);
  end

  always_comb begin
    low6 = '0;
    for (int x = 0; x < NUM_LOW; x++)
      if (hit6N[x] || hit6P[x]) low6 = LOW_W'(x);
  end

  assign hit6[0]  = |hit6N;
  assign hit6[1]  = |hit6P;
  assign isK28[0] = (s6 == K28_SUB6);
  assign isK28[1] = (s6 == ~K28_SUB6);

  function automatic pathRes_t resolvePath(input logic rdStart, input logic h6,
                                           input logic k28, input logic [LOW_W-1:0] x,
                                           input logic [SUB6_W-1:0] c6,
                                           input logic [SUB4_W-1:0] c4);
    pathRes_t         res;
    logic             rdMid;
    logic [SUB4_W-1:0] cand;
    int               ones6;
    ones6 = $countones(c6);
    rdMid = rdStart ? (ones6 >= 3) : (ones6 > 3);
    res = '0;
    if (k28) begin
      for (int y = 0; y < (1 << HIGH_W); y++) begin
        cand = k28Sub4Neg(HIGH_W'(y));
        if (rdMid) cand = ~cand;
        if (c4 == cand) res = '{ok: 1'b1, ctrl: 1'b1, value: {HIGH_W'(y), 5'd28}};
      end
    end else if (h6) begin
      for (int y = 0; y < 7; y++) begin
        cand = sub4Neg(HIGH_W'(y));
        if (rdMid && flips4(cand)) cand = ~cand;
        if (c4 == cand) res = '{ok: 1'b1, ctrl: 1'b0, value: {HIGH_W'(y), x}};
      end
      if (c4 == (rdMid ? ~PRI7_NEG : PRI7_NEG) && !needAlt(x, rdMid))
        res = '{ok: 1'b1, ctrl: 1'b0, value: {3'd7, x}};
      if (c4 == (rdMid ? ~ALT7_NEG : ALT7_NEG)) begin
        if (needAlt(x, rdMid))
          res = '{ok: 1'b1, ctrl: 1'b0, value: {3'd7, x}};
        else if (isKx7(x))
          res = '{ok: 1'b1, ctrl: 1'b1, value: {3'd7, x}};
      end
    end
    return res;
  endfunction

  // Index 0 assumes negative starting disparity, index 1 positive
  for (genvar gp = 0; gp < 2; gp++) begin : g_path
    assign pathR[gp] = resolvePath(gp[0], hit6[gp], isK28[gp], low6, s6, s4);
  end

  assign codeOk  = pathR[0].ok || pathR[1].ok;
  assign ctrlDec = pathR[0].ok ? pathR[0].ctrl  : pathR[1].ctrl;
  assign byteDec = pathR[0].ok ? pathR[0].value : pathR[1].value;

  assign wordIsIdle = codeOk && ctrlDec && (byteDec == IDLE_BYTE);
  assign wordPos    = $countones(inWord) > NEUTRAL_ONES;
  assign wordNeg    = $countones(inWord) < NEUTRAL_ONES;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outCodeErr <= 1'b0;
      outDispErr <= 1'b0;
      outCtrl    <= 1'b0;
      outByte    <= '0;
    end else begin
      outValid   <= strobes.keep;
      outCodeErr <= strobes.keep && !codeOk;
      outDispErr <= strobes.keep && strobes.dispErr;
      outCtrl    <= ctrlDec;
      outByte    <= byteDec;
    end
  end

endmodule

// File: rtl/dec8b10b_idle.sv
module dec8b10b_idle
  import dec8b10b_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idleDelAsync,
  input  logic [WORD_W-1:0] inWord,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              outCtrl,
  output logic              outCodeErr,
  output logic              outDispErr
);

  strobe_t strobes;
  logic    wordIsIdle, wordPos, wordNeg;
  logic    delEn, rdPos;

  dec8b10b_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .idleDelAsync (idleDelAsync),
    .wordIsIdle   (wordIsIdle),
    .wordPos      (wordPos),
    .wordNeg      (wordNeg),
    .strobes      (strobes),
    .delEn        (delEn),
    .rdPos        (rdPos)
  );

  dec8b10b_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inWord     (inWord),
    .strobes    (strobes),
    .wordIsIdle (wordIsIdle),
    .wordPos    (wordPos),
    .wordNeg    (wordNeg),
    .outValid   (outValid),
    .outByte    (outByte),
    .outCtrl    (outCtrl),
    .outCodeErr (outCodeErr),
    .outDispErr (outDispErr)
  );

endmodule

// File: rtl/dec8b10b_idle_chk.sv
module dec8b10b_idle_chk (
  input logic       clk,
  input logic       rstN,
  input logic       idleDelAsync,
  input logic [9:0] inWord,
  input logic       outValid,
  input logic [7:0] outByte,
  input logic       outCtrl,
  input logic       outCodeErr,
  input logic       outDispErr,
  input logic       delEn,
  input logic       rdPos
);

  localparam logic [9:0] IDLE_WORD_N = 10'h17C;
  localparam logic [9:0] IDLE_WORD_P = 10'h283;

  logic prevInReset = 1'b0;

  always_ff @(posedge clk) begin
    prevInReset <= !rstN;
    // R9
    if (prevInReset) begin
      reset_quiet_chk: assert (!outValid && !outCodeErr && !outDispErr)
        else $error("outputs active after a reset cycle");
    end
  end

  // R5
  rd_follow_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(inWord) < 5) |=> !rdPos);

  // R5
  rd_follow_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(inWord) > 5) |=> rdPos);

  // R4
  disp_pos_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdPos && $countones(inWord) > 5) |=> (!outValid || outDispErr));

  // R6
  idle_dropped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (delEn && (inWord == IDLE_WORD_N || inWord == IDLE_WORD_P)) |=> !outValid);

  // R7
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(delEn) |-> $past(idleDelAsync, 3));

  // R7
  sync_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(delEn) |-> !$past(idleDelAsync, 3));

  // R2
  ctrl_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCtrl && !outCodeErr) |-> (outByte[4:0] == 5'd28 || outByte[7:5] == 3'd7));

endmodule

bind dec8b10b_idle dec8b10b_idle_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .idleDelAsync (idleDelAsync),
  .inWord       (inWord),
  .outValid     (outValid),
  .outByte      (outByte),
  .outCtrl      (outCtrl),
  .outCodeErr   (outCodeErr),
  .outDispErr   (outDispErr),
  .delEn        (delEn),
  .rdPos        (rdPos)
);

// File: tb/tb_dec8b10b_idle.sv
module tb_dec8b10b_idle;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idleDelAsync = 1'b0;
  logic [9:0] inWord = '0;
  logic       outValid, outCtrl, outCodeErr, outDispErr;
  logic [7:0] outByte;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dec8b10b_idle dut (
    .clk(clk), .rstN(rstN), .idleDelAsync(idleDelAsync), .inWord(inWord),
    .outValid(outValid), .outByte(outByte), .outCtrl(outCtrl),
    .outCodeErr(outCodeErr), .outDispErr(outDispErr)
  );

  // Independent encoder tables
  logic [5:0] t6 [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101,
    6'b101001, 6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
    6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011, 6'b010011,
    6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010, 6'b110011, 6'b100110,
    6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
  logic [3:0] t4 [7] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110};
  logic [3:0] tk [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100, 4'b1101, 4'b0101, 4'b1001, 4'b0111};
  logic [7:0] kList [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                             8'hF7, 8'hFB, 8'hFD, 8'hFE};

  // Legal code groups: {ctrl, byte}
  logic [8:0] refMap [logic [9:0]];

  // Model state
  bit mRd = 0;
  bit mSync [3] = '{0, 0, 0};
  bit txRd = 0;
  logic expValid, expCtrl, expCE, expDE;
  logic [7:0] expByte;

  function automatic void enc(input logic [7:0] b, input bit k, input bit rdIn,
                              output logic [9:0] w, output bit rdOut);
    logic [5:0] c6;
    logic [3:0] c4;
    bit r1, useAlt;
    int x, y;
    x = int'(b[4:0]);
    y = int'(b[7:5]);
    c6 = (k && x == 28) ? 6'b001111 : t6[x];
    if (rdIn && ($countones(c6) != 3 || c6 == 6'b111000)) c6 = ~c6;
    r1 = ($countones(c6) == 4) ? 1 : ($countones(c6) == 2) ? 0 : rdIn;
    if (k && x == 28) begin
      c4 = tk[y];
      if (r1) c4 = ~c4;
    end else begin
      if (y == 7) begin
        useAlt = k || (!r1 && (x == 17 || x == 18 || x == 20)) ||
                 (r1 && (x == 11 || x == 13 || x == 14));
        c4 = useAlt ? 4'b0111 : 4'b1110;
      end else c4 = t4[y];
      if (r1 && ($countones(c4) != 2 || c4 == 4'b1100)) c4 = ~c4;
    end
    rdOut = ($countones(c4) == 3) ? 1 : ($countones(c4) == 1) ? 0 : r1;
    for (int i = 0; i < 6; i++) w[i] = c6[5-i];
    for (int i = 0; i < 4; i++) w[6+i] = c4[3-i];
  endfunction

  task automatic buildMap();
    logic [9:0] w;
    bit r;
    for (int rd = 0; rd < 2; rd++) begin
      for (int b = 0; b < 256; b++) begin
        enc(8'(b), 0, bit'(rd), w, r);
        refMap[w] = {1'b0, 8'(b)};
      end
      for (int i = 0; i < 12; i++) begin
        enc(kList[i], 1, bit'(rd), w, r);
        refMap[w] = {1'b1, kList[i]};
      end
    end
  endtask

  task automatic model(input logic [9:0] w, input logic del);
    int ones;
    bit legal, dropped;
    ones = $countones(w);
    legal = refMap.exists(w);
    expCtrl = legal ? refMap[w][8] : 1'b0;
    expByte = legal ? refMap[w][7:0] : 8'h00;
    dropped = mSync[2] && legal && expCtrl && expByte == 8'hBC;
    expValid = !dropped;
    expCE = expValid && !legal;
    expDE = expValid && (mRd ? (ones > 5) : (ones < 5));
    if (ones > 5) mRd = 1;
    else if (ones < 5) mRd = 0;
    mSync[2] = mSync[1];
    mSync[1] = mSync[0];
    mSync[0] = del;
  endtask

  task automatic check1(input string tag, input string field, input logic [7:0] got,
                        input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, field, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    check1(tag, "valid (R6/R8)", {7'd0, outValid}, {7'd0, expValid});
    if (expValid) begin
      check1(tag, "codeErr (R3)", {7'd0, outCodeErr}, {7'd0, expCE});
      check1(tag, "dispErr (R4/R5)", {7'd0, outDispErr}, {7'd0, expDE});
      if (!expCE) begin
        check1(tag, "ctrl (R1/R2)", {7'd0, outCtrl}, {7'd0, expCtrl});
        check1(tag, "byte (R1/R2)", outByte, expByte);
      end
    end
  endtask

  // Called just after a negative edge
  task automatic drive(input logic [9:0] w, input logic del, input string tag);
    inWord = w;
    idleDelAsync = del;
    @(posedge clk);
    model(w, del);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic sendChar(input logic [7:0] b, input bit k, input logic del, input string tag);
    logic [9:0] w;
    bit r;
    enc(b, k, txRd, w, r);
    txRd = r;
    drive(w, del, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    buildMap();
    // R9: reset state
    repeat (3) @(negedge clk);
    check1("R9", "valid", {7'd0, outValid}, 8'd0);
    check1("R9", "codeErr", {7'd0, outCodeErr}, 8'd0);
    check1("R9", "dispErr", {7'd0, outDispErr}, 8'd0);
    rstN = 1'b1;

    // R1, R8: encoded data stream
    for (int i = 0; i < 256; i++) sendChar(8'(i * 37 + 5), 0, 0, "R1");
    // R2: every control character, both polarities over two passes
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 12; i++) sendChar(kList[i], 1, 0, "R2");
    // R10: idles kept while removal is off
    for (int i = 0; i < 6; i++) sendChar(8'hBC, 1, 0, "R10");

    // R4, R5: repeated same-polarity words
    drive(10'h17C, 0, "R4");
    drive(10'h17C, 0, "R4");
    drive(10'h283, 0, "R4");
    drive(10'h283, 0, "R4");
    drive(10'h3FF, 0, "R5");
    drive(10'h000, 0, "R5");
    drive(10'h01F, 0, "R5");
    drive(10'h000, 0, "R5");

    // R3: every line word with removal off
    for (int i = 0; i < 1024; i++) drive(10'(i), 0, "R3");

    // R7: removal turned on mid idle stream, then off again
    txRd = mRd;
    for (int i = 0; i < 8; i++) sendChar(8'hBC, 1, 1, "R7");
    for (int i = 0; i < 6; i++) sendChar(8'hBC, 1, 0, "R7");

    // R6: mixed data and idles with removal on
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) sendChar(8'hBC, 1, 1, "R6");
      else if (i % 7 == 0) sendChar(8'h3C, 1, 1, "R6");
      else sendChar(8'(i * 11), 0, 1, "R6");
    end
    // R6: every line word with removal on
    for (int i = 0; i < 1024; i++) drive(10'(i), 1, "R6");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule